// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block collects 64 interrupt sources into two banks of 32 and raises a single interrupt request toward a processor. Each source is either edge-type or level-type; the choice is fixed at build time by a level-type mask. Edge-type sources are synchronized and captured in a per-bank event word. Level-type sources are never captured and are only seen through the live level word. Software clears captured events by writing ones to an acknowledge word and selects which sources may interrupt through an enable word.

A bank's pending word is its event word, ORed with the live level word filtered through the level-type mask, then ANDed with its enable word. The request output is the OR of all pending bits. Alongside it the block gives a registered source number: the highest-numbered pending source, with the upper bank searched before the lower one. Software reaches the registers through a plain 32-bit read/write port. Reads are combinational on the address.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Address map within a 64-byte window. Bank 1's group starts at 0x10 and bank 0's at 0x20. Inside a group, byte offset 0x0 is event, 0x4 is enable, 0x8 is acknowledge and 0xC is level. Source n is bit n&31 of bank n>>5. Addresses 0x00–0x0F and 0x30–0x3F read as zero and writes to them change nothing.
- R2: An edge-type input passes through a two-flop synchronizer. A synchronized rising edge sets that source's event bit whether or not the source is enabled. An input held high sets it only once.
- R3: Writing 1 to an acknowledge bit clears that event bit on the next clock edge. Acknowledge bits written as 0 leave their event bits unchanged.
- R4: If an event is set and acknowledged on the same clock edge, the event bit ends up set.
- R5: The level register reads the synchronized live state of all 32 inputs of its bank. Level-type sources never set event bits. They pend while their synchronized input is high and enabled. Default level-type mask: bank 0 = 0x1FF00000 (sources 20–28), bank 1 = 0.
- R6: Pending = (event | (level & levelMask)) & enable. The request output irqOut is the OR of all pending bits, registered once.
- R7: vecId reports the highest-numbered pending source, as {bank, bit}. Any pending bit in bank 1 wins over every bit in bank 0.
- R8: vecValid is high in exactly the cycles where irqOut is high, and vecId is registered in the same cycle as irqOut.
- R9: Setting an enable bit while an edge-type input is already held high does not set its event bit and does not raise a request.
- R10: After reset, all event and enable words are zero, and irqOut and vecValid are low.
- R11: Writes to event or level registers change no state. Reads of an acknowledge register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srcIn | input | 64 | Raw interrupt source inputs, bit n is source n |
| regAddr | input | 6 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| irqOut | output | 1 | Interrupt request |
| vecValid | output | 1 | vecId holds a pending source |
| vecId | output | 6 | Highest-numbered pending source |

## Verification
Two functions can meet in one clock cycle. One is the capture of a synchronized rising edge into the event word. The other is a software acknowledge of that same bit. The bench drives an acknowledge write so that it lands exactly on the edge where the capture happens, then reads the event word and expects the bit to remain set. During the random phase, random source toggles and random acknowledge writes collide freely. Every cycle, a cycle-accurate reference computed from the requirements judges the request, source number and read data.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int IRQ_BANKS = 2;
  localparam int IRQ_WIDTH = 32;

  // word offset inside a bank group, decoded from address bits [3:2]
  typedef enum logic [1:0] {
    FLD_EVENT  = 2'd0,
    FLD_ENABLE = 2'd1,
    FLD_ACK    = 2'd2,
    FLD_LEVEL  = 2'd3
  } reg_field_e;

  typedef struct packed {
    logic [IRQ_BANKS-1:0] enableWr;
    logic [IRQ_BANKS-1:0] ackWr;
    logic [IRQ_BANKS-1:0] bankSel;
    reg_field_e           field;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_reg_ctrl.sv
module irq_reg_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = IRQ_BANKS,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrl_strobe_t      strb
);
  localparam int GRP_W = ADDR_W - 4;

  logic [GRP_W-1:0] grpIdx;
  reg_field_e       fieldSel;

  assign grpIdx   = regAddr[ADDR_W-1:4];
  assign fieldSel = reg_field_e'(regAddr[3:2]);

  always_comb begin
    strb       = '0;
    strb.field = fieldSel;
    for (int b = 0; b < NUM_BANKS; b++) begin
      // bank b sits at group (NUM_BANKS - b)
      strb.bankSel[b]  = (grpIdx == GRP_W'(NUM_BANKS - b));
      strb.enableWr[b] = regWrEn && strb.bankSel[b] && (fieldSel == FLD_ENABLE);
      strb.ackWr[b]    = regWrEn && strb.bankSel[b] && (fieldSel == FLD_ACK);
    end
  end

  // R1
  bank_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb.bankSel));

  // R1
  write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.enableWr, strb.ackWr}));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++)
      if (req[i]) idx = IDX_W'(i);
  end
  assign any = |req;
endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS   = IRQ_BANKS,
  parameter int BANK_W      = IRQ_WIDTH,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = 64'h0000_0000_1FF0_0000,
  localparam int SRC_N  = NUM_BANKS * BANK_W,
  localparam int BIT_W  = $clog2(BANK_W),
  localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ID_W   = BSEL_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  srcIn,
  input  logic [BANK_W-1:0] regWrData,
  input  ctrl_strobe_t      strb,
  output logic [BANK_W-1:0] regRdData,
  output logic              irqOut,
  output logic              vecValid,
  output logic [ID_W-1:0]   vecId
);
  // synchronizer chain
  logic [SRC_N-1:0] syncPipe [SYNC_STAGES];
  logic [SRC_N-1:0] liveLvl, prevLvl, riseVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncPipe[0] <= '0;
    else        syncPipe[0] <= srcIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syncPipe[s] <= '0;
      else        syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign liveLvl = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLvl <= '0;
    else        prevLvl <= liveLvl;
  end

  // only edge-type sources capture
  assign riseVec = liveLvl & ~prevLvl & ~LEVEL_MASK;

  logic [NUM_BANKS-1:0][BANK_W-1:0] eventQ, enableQ, pendW, ackMask;
  logic [NUM_BANKS-1:0]             bankAny;
  logic [NUM_BANKS-1:0][BIT_W-1:0]  bankIdx;
  logic [SRC_N-1:0]                 pendFlat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] riseB, lvlB, maskB;
    assign riseB = riseVec[b*BANK_W +: BANK_W];
    assign lvlB  = liveLvl[b*BANK_W +: BANK_W];
    assign maskB = LEVEL_MASK[b*BANK_W +: BANK_W];
    assign ackMask[b] = strb.ackWr[b] ? regWrData : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        eventQ[b]  <= '0;
        enableQ[b] <= '0;
      end else begin
        // a capture in the same cycle as its acknowledge survives
        eventQ[b] <= (eventQ[b] & ~ackMask[b]) | riseB;
        if (strb.enableWr[b]) enableQ[b] <= regWrData;
      end
    end

    assign pendW[b] = (eventQ[b] | (lvlB & maskB)) & enableQ[b];

    irq_prio_enc #(.W(BANK_W), .IDX_W(BIT_W)) u_enc (
      .req(pendW[b]),
      .any(bankAny[b]),
      .idx(bankIdx[b])
    );
  end

  assign pendFlat = pendW;

  // upper bank wins
  logic [BSEL_W-1:0] winBank;
  logic              winAny;
  always_comb begin
    winBank = '0;
    winAny  = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankAny[b]) begin
        winBank = BSEL_W'(b);
        winAny  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqOut   <= 1'b0;
      vecValid <= 1'b0;
      vecId    <= '0;
    end else begin
      irqOut   <= |pendFlat;
      vecValid <= winAny;
      vecId    <= {winBank, bankIdx[winBank]};
    end
  end

  // register read mux
  always_comb begin
    regRdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (strb.bankSel[b]) begin
        case (strb.field)
          FLD_EVENT:  regRdData = eventQ[b];
          FLD_ENABLE: regRdData = enableQ[b];
          FLD_LEVEL:  regRdData = liveLvl[b*BANK_W +: BANK_W];
          default:    regRdData = '0;
        endcase
      end
    end
  end

  // R2
  event_set_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((eventQ & ~$past(eventQ) & ~$past(riseVec)) == '0));

  // R3
  ack_clears_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((eventQ & $past(ackMask & ~riseVec)) == '0));

  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> $past(|enableQ));

  // R7
  highest_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> (($past(pendFlat) >> vecId) == SRC_N'(1)));

  // R8
  valid_tracks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid == irqOut);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS   = IRQ_BANKS,
  parameter int BANK_W      = IRQ_WIDTH,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = 64'h0000_0000_1FF0_0000,
  localparam int SRC_N  = NUM_BANKS * BANK_W,
  localparam int ADDR_W = $clog2((NUM_BANKS + 2) * 16),
  localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ID_W   = BSEL_W + $clog2(BANK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  srcIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BANK_W-1:0] regWrData,
  output logic [BANK_W-1:0] regRdData,
  output logic              irqOut,
  output logic              vecValid,
  output logic [ID_W-1:0]   vecId
);
  ctrl_strobe_t strb;

  irq_reg_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strb(strb)
  );

  irq_bank_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W(BANK_W),
    .SYNC_STAGES(SYNC_STAGES),
    .LEVEL_MASK(LEVEL_MASK)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .srcIn(srcIn),
    .regWrData(regWrData),
    .strb(strb),
    .regRdData(regRdData),
    .irqOut(irqOut),
    .vecValid(vecValid),
    .vecId(vecId)
  );
endmodule

// File: tb/tb_banked_irq_ctrl.sv
`timescale 1ns/1ps
module tb_banked_irq_ctrl;
  localparam logic [63:0] LM = 64'h0000_0000_1FF0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] srcIn = '0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut, vecValid;
  logic [5:0]  vecId;

  int nChecks = 0;
  int nFails  = 0;
  bit cmpOn   = 1'b0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  banked_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .vecValid(vecValid), .vecId(vecId)
  );

  // reference state built from the requirements
  logic [63:0] rS1, rS2, rPrev, rEv, rEn;
  logic        rIrq, rValid;
  logic [5:0]  rId;

  function automatic int bankOf(logic [5:0] a);
    if (a[5:4] == 2'd2) return 0;
    if (a[5:4] == 2'd1) return 1;
    return -1;
  endfunction

  function automatic logic [63:0] pendOf(logic [63:0] ev, logic [63:0] lv, logic [63:0] en);
    return (ev | (lv & LM)) & en;
  endfunction

  function automatic int highOf(logic [63:0] v);
    for (int i = 63; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] expRead(logic [5:0] a);
    int b;
    b = bankOf(a);
    if (b < 0) return '0;
    case (a[3:2])
      2'd0: return rEv[b*32 +: 32];
      2'd1: return rEn[b*32 +: 32];
      2'd3: return rS2[b*32 +: 32];
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rS1 <= '0; rS2 <= '0; rPrev <= '0; rEv <= '0; rEn <= '0;
      rIrq <= 1'b0; rValid <= 1'b0; rId <= '0;
    end else begin
      logic [63:0] ackM, nEn, p;
      int b;
      b = bankOf(regAddr);
      ackM = '0;
      nEn = rEn;
      if (regWrEn && b >= 0 && regAddr[3:2] == 2'd2) ackM[b*32 +: 32] = regWrData;
      if (regWrEn && b >= 0 && regAddr[3:2] == 2'd1) nEn[b*32 +: 32] = regWrData;
      p = pendOf(rEv, rS2, rEn);
      rS1 <= srcIn;
      rS2 <= rS1;
      rPrev <= rS2;
      rEv <= (rEv & ~ackM) | (rS2 & ~rPrev & ~LM);
      rEn <= nEn;
      rIrq <= |p;
      rValid <= |p;
      rId <= (|p) ? 6'(highOf(p)) : 6'd0;
    end
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (cmpOn && rst_n) begin
      check(irqOut == rIrq, "R6 irqOut", 64'(irqOut), 64'(rIrq));
      check(vecValid == rValid, "R8 vecValid", 64'(vecValid), 64'(rValid));
      if (rValid) check(vecId == rId, "R7 vecId", 64'(vecId), 64'(rId));
    end
  end

  task automatic regWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readBit(logic [5:0] a, int bitN, bit expB, string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData[bitN] == expB, tag, 64'(regRdData[bitN]), 64'(expB));
  endtask

  task automatic readWord(logic [5:0] a, logic [31:0] expW, string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData == expW, tag, 64'(regRdData), 64'(expW));
  endtask

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(int n);
    @(negedge clk); srcIn[n] = 1'b1;
    waitCyc(3);
    srcIn[n] = 1'b0;
    waitCyc(4);
  endtask

  task automatic outChk(bit expIrq, logic [5:0] expId, string tag);
    @(negedge clk);
    #1;
    check(irqOut == expIrq, {tag, " irq"}, 64'(irqOut), 64'(expIrq));
    if (expIrq) check(vecId == expId, {tag, " id"}, 64'(vecId), 64'(expId));
  endtask

  initial begin
    void'($urandom(32'd2024));
    waitCyc(3);
    rst_n = 1'b1;
    cmpOn = 1'b1;

    // R10 reset state
    outChk(1'b0, 6'd0, "R10");
    readWord(6'h24, 32'h0, "R10 enable bank0");
    readWord(6'h14, 32'h0, "R10 enable bank1");
    readWord(6'h20, 32'h0, "R10 event bank0");

    // R2 capture while disabled; R1 bank placement
    pulse(5);
    readBit(6'h20, 5, 1'b1, "R2 event bit5 while disabled");
    outChk(1'b0, 6'd0, "R2 disabled no irq");
    pulse(37);
    readBit(6'h10, 5, 1'b1, "R1 source37 in bank1 group");
    readBit(6'h20, 5, 1'b1, "R1 bank0 group separate");

    // R3 acknowledge
    regWrite(6'h28, 32'h0);
    readBit(6'h20, 5, 1'b1, "R3 ack zero keeps event");
    regWrite(6'h28, 32'h20);
    readBit(6'h20, 5, 1'b0, "R3 ack one clears event");

    // R6 enable and request
    regWrite(6'h24, 32'h80);
    pulse(7);
    outChk(1'b1, 6'd7, "R6");

    // R7 priority across banks
    regWrite(6'h18, 32'hFFFF_FFFF);
    regWrite(6'h14, 32'hFFFF_FFFF);
    pulse(33);
    outChk(1'b1, 6'd33, "R7 bank1 over bank0");
    pulse(50);
    outChk(1'b1, 6'd50, "R7 highest in bank");
    regWrite(6'h18, 32'hFFFF_FFFF);
    regWrite(6'h28, 32'hFFFF_FFFF);
    regWrite(6'h14, 32'h0);

    // R5 level-type source 22
    regWrite(6'h24, 32'h0040_0000);
    @(negedge clk); srcIn[22] = 1'b1;
    waitCyc(4);
    outChk(1'b1, 6'd22, "R5 level pends");
    readBit(6'h2C, 22, 1'b1, "R5 level reads live");
    readBit(6'h20, 22, 1'b0, "R5 level not captured");
    @(negedge clk); srcIn[22] = 1'b0;
    waitCyc(4);
    outChk(1'b0, 6'd0, "R5 level released");

    // R9 enabling an already-held edge source
    @(negedge clk); srcIn[10] = 1'b1;
    waitCyc(4);
    readBit(6'h20, 10, 1'b1, "R2 held source captured once");
    regWrite(6'h28, 32'h400);
    waitCyc(2);
    regWrite(6'h24, 32'h400);
    waitCyc(5);
    outChk(1'b0, 6'd0, "R9 no request");
    readBit(6'h20, 10, 1'b0, "R9 no recapture");

    // R4 capture and acknowledge on the same edge
    @(negedge clk); srcIn[12] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regAddr = 6'h28; regWrData = 32'h1000; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    readBit(6'h20, 12, 1'b1, "R4 set beats ack");
    regWrite(6'h28, 32'h1000);
    readBit(6'h20, 12, 1'b0, "R3 later ack clears");

    // R11 ignored writes, ack reads zero; R1 unmapped space
    pulse(3);
    regWrite(6'h20, 32'h0);
    readBit(6'h20, 3, 1'b1, "R11 event write ignored");
    regWrite(6'h2C, 32'h0);
    readBit(6'h2C, 10, 1'b1, "R11 level write ignored");
    readWord(6'h28, 32'h0, "R11 ack reads zero");
    regWrite(6'h04, 32'hFFFF_FFFF);
    regWrite(6'h34, 32'hFFFF_FFFF);
    readWord(6'h24, 32'h400, "R1 unmapped write no effect");
    readWord(6'h04, 32'h0, "R1 unmapped low reads zero");
    readWord(6'h34, 32'h0, "R1 unmapped high reads zero");

    // random phase
    for (int c = 0; c < 600; c++) begin
      logic [63:0] flip;
      logic [5:0]  a;
      @(negedge clk);
      flip = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      srcIn = srcIn ^ flip;
      a = 6'($urandom_range(0, 15) << 2);
      regAddr = a;
      regWrEn = ($urandom_range(0, 2) == 0);
      regWrData = ($urandom_range(0, 1) == 0) ? $urandom : ($urandom & $urandom);
      #1;
      check(regRdData == expRead(a), "R1 random read", 64'(regRdData), 64'(expRead(a)));
    end
    @(negedge clk);
    regWrEn = 1'b0;
    waitCyc(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule